// File: doc/BRIEF.md
# Load/Store Port with Local Byte Memory

This block serves one requester that issues loads and stores, one at a time, into a small private memory. The memory is built from 64-bit words, and each word is divided into eight byte lanes in little-endian order. For each operation the requester holds a load or store request line high and supplies an access size of 1, 2, 4 or 8 bytes. It also presents a byte address together with an address-valid flag. The block accepts the address and raises an acknowledge that stays high until the operation ends. For a store, it then takes the data on a single-cycle data-valid pulse. For a load, it returns the data zero-extended to 64 bits and raises a load-ok flag.

The requester ends every operation by dropping its request and address-valid lines, and the block then returns to idle. A busy output tells the requester when it may start the next operation. A privilege-mode bit is captured with each accepted request and driven back out unchanged. No address translation is performed.

Top module: `ldst_port`

## Requirements
- R1: When the block is idle (busy_o low, addr_ack_o low) and addr_vld_i is high with ld_req_i or st_req_i, addr_ack_o is high after the next clock edge. It stays high until the block returns to idle.
- R2: size_i encodes the access width as 0=1, 1=2, 2=4, 3=8 bytes. Address bits [2:0] select the starting byte lane, and the bits above them select the word. Accesses are naturally aligned.
- R3: A store writes its bytes on the edge where st_vld_i is high with the address acknowledged. It writes only the lanes covered by the access, taken from the low bytes of st_data_i, and leaves every other byte unchanged.
- R4: In the cycle after the store data is captured, busy_o is high. In the following cycle busy_o is low, even though the requester still holds its request.
- R5: A load raises ld_ok_o, with ld_data_o valid, three clock edges after the request is first presented to an idle block. ld_ok_o and busy_o then stay high until the requester drops its request.
- R6: Bytes are little-endian. The byte at address A appears in ld_data_o[7:0]. Lanes beyond the access size read as zero.
- R7: A st_vld_i pulse while the block is idle, or during a load, changes no memory byte.
- R8: If ld_req_i, st_req_i and addr_vld_i are all low in any state, the block is idle after the next edge: busy_o, addr_ack_o and ld_ok_o are low. A store dropped before its data pulse writes nothing.
- R9: priv_o equals the value of priv_i at the moment the request was accepted. It holds that value until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req_i | input | 1 | Load request, held for the whole operation |
| st_req_i | input | 1 | Store request, held for the whole operation |
| size_i | input | 2 | Access width code (1/2/4/8 bytes) |
| priv_i | input | 1 | Privilege mode (1 virtual, 0 real) |
| addr_i | input | ADDR_W | Byte address |
| addr_vld_i | input | 1 | Address valid |
| st_data_i | input | 64 | Store data, right-aligned |
| st_vld_i | input | 1 | Store data valid pulse |
| busy_o | output | 1 | Block cannot start a new operation |
| addr_ack_o | output | 1 | Address accepted |
| ld_data_o | output | 64 | Load result, zero-extended |
| ld_ok_o | output | 1 | Load result valid |
| priv_o | output | 1 | Privilege bit captured at acceptance |

## Verification
The situations hardest to reach from the ports are a request dropped halfway through an operation and a stray data pulse that arrives outside the store data phase. The bench reaches them by stopping its handshake tasks early: it drops the lines right after the acknowledge, and it pulses st_vld_i while idle and inside a load. It then reads the affected bytes back through ordinary loads. Alongside this, a sweep covers every size and every aligned offset across several words, and a reference byte array checks each readback at two widths.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR_ACK, S_ST_WAIT, S_ST_COMMIT, S_LD_READ, S_LD_DONE, S_DRAIN
  } ldst_state_t;

  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'(4'd1 << sz);
  endfunction

  function automatic logic [7:0] lane_mask(input logic [1:0] sz, input logic [2:0] off);
    logic [15:0] m;
    m = (16'd1 << size_bytes(sz)) - 16'd1;
    m = m << off;
    return m[7:0];
  endfunction

  function automatic logic [63:0] place_bytes(input logic [63:0] d, input logic [2:0] off);
    return d << {off, 3'b000};
  endfunction

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_req_i,
  input  logic        st_req_i,
  input  logic        addr_vld_i,
  input  logic        st_vld_i,
  output ldst_state_t state_o,
  output logic        accept_o,
  output logic        st_cap_o,
  output logic        rd_en_o
);

  ldst_state_t state_q, state_d;
  logic        is_st_q;
  logic        drop;

  assign drop = !ld_req_i && !st_req_i && !addr_vld_i;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    st_cap_o = 1'b0;
    rd_en_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if ((ld_req_i || st_req_i) && addr_vld_i) begin
          accept_o = 1'b1;
          state_d  = S_ADDR_ACK;
        end
      end
      S_ADDR_ACK: begin
        if (drop) state_d = S_IDLE;
        else if (is_st_q) begin
          if (st_vld_i) begin
            st_cap_o = 1'b1;
            state_d  = S_ST_COMMIT;
          end else state_d = S_ST_WAIT;
        end else state_d = S_LD_READ;
      end
      S_ST_WAIT: begin
        if (drop) state_d = S_IDLE;
        else if (st_vld_i) begin
          st_cap_o = 1'b1;
          state_d  = S_ST_COMMIT;
        end
      end
      S_ST_COMMIT: state_d = drop ? S_IDLE : S_DRAIN;
      S_LD_READ: begin
        if (drop) state_d = S_IDLE;
        else begin
          rd_en_o = 1'b1;
          state_d = S_LD_DONE;
        end
      end
      S_LD_DONE: if (drop) state_d = S_IDLE;
      S_DRAIN:   if (drop) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      is_st_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) is_st_q <= st_req_i;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/ldst_lanes.sv
module ldst_lanes
  import ldst_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [1:0]         size_i,
  input  logic [2:0]         off_i,
  input  logic [63:0]        st_data_i,
  input  logic [63:0]        rd_word_i,
  output logic [LANES-1:0]   wr_mask_o,
  output logic [63:0]        wr_data_o,
  output logic [63:0]        ld_data_o
);

  logic [63:0] shifted;
  logic [3:0]  nbytes;

  assign wr_mask_o = lane_mask(size_i, off_i);
  assign wr_data_o = place_bytes(st_data_i, off_i);
  assign shifted   = rd_word_i >> {off_i, 3'b000};
  assign nbytes    = size_bytes(size_i);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign ld_data_o[b*8 +: 8] = (4'(b) < nbytes) ? shifted[b*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/ldst_mem.sv
module ldst_mem #(
  parameter int WORDS = 16,
  parameter int LANES = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [63:0]      wdata_i,
  input  logic             re_i,
  output logic [63:0]      rdata_o
);

  logic [63:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int b = 0; b < LANES; b++) begin
        if (mask_i[b]) mem[idx_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
      end
    end
    if (re_i) rdata_o <= mem[idx_i];
  end

endmodule

// File: rtl/ldst_port.sv
module ldst_port
  import ldst_pkg::*;
#(
  parameter int WORDS = 16,
  localparam int LANES  = 8,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req_i,
  input  logic              st_req_i,
  input  logic [1:0]        size_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  input  logic [63:0]       st_data_i,
  input  logic              st_vld_i,
  output logic              busy_o,
  output logic              addr_ack_o,
  output logic [63:0]       ld_data_o,
  output logic              ld_ok_o,
  output logic              priv_o
);

  ldst_state_t       state;
  logic              accept, st_cap, rd_en;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              priv_q;
  logic [LANES-1:0]  wr_mask;
  logic [63:0]       wr_data, rd_word, ld_data;

  ldst_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_req_i(ld_req_i), .st_req_i(st_req_i),
    .addr_vld_i(addr_vld_i), .st_vld_i(st_vld_i), .state_o(state),
    .accept_o(accept), .st_cap_o(st_cap), .rd_en_o(rd_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= '0;
      priv_q <= 1'b0;
    end else if (accept) begin
      addr_q <= addr_i;
      size_q <= size_i;
      priv_q <= priv_i;
    end
  end

  ldst_lanes #(.LANES(LANES)) u_lanes (
    .size_i(size_q), .off_i(addr_q[2:0]), .st_data_i(st_data_i),
    .rd_word_i(rd_word), .wr_mask_o(wr_mask), .wr_data_o(wr_data),
    .ld_data_o(ld_data)
  );

  ldst_mem #(.WORDS(WORDS), .LANES(LANES)) u_mem (
    .clk(clk), .we_i(st_cap), .mask_i(wr_mask), .idx_i(addr_q[ADDR_W-1:3]),
    .wdata_i(wr_data), .re_i(rd_en), .rdata_o(rd_word)
  );

  assign busy_o     = (state != S_IDLE) && (state != S_DRAIN);
  assign addr_ack_o = (state != S_IDLE);
  assign ld_ok_o    = (state == S_LD_DONE);
  assign ld_data_o  = ld_ok_o ? ld_data : 64'd0;
  assign priv_o     = priv_q;

endmodule

// File: rtl/ldst_port_chk.sv
module ldst_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_req_i,
  input logic st_req_i,
  input logic addr_vld_i,
  input logic busy_o,
  input logic addr_ack_o,
  input logic ld_ok_o,
  input logic priv_o,
  input logic accept,
  input logic st_cap
);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !addr_ack_o && addr_vld_i && (ld_req_i || st_req_i)) |=> addr_ack_o);

  assert_capture_acked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_cap |-> (addr_ack_o && busy_o));

  assert_commit_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_cap && (ld_req_i || st_req_i || addr_vld_i)) |=> busy_o);

  assert_ldok_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ok_o |-> (busy_o && addr_ack_o));

  assert_drop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_req_i && !st_req_i && !addr_vld_i) |=> (!busy_o && !addr_ack_o && !ld_ok_o));

  assert_priv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(priv_o));

endmodule

bind ldst_port ldst_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_req_i(ld_req_i), .st_req_i(st_req_i),
  .addr_vld_i(addr_vld_i), .busy_o(busy_o), .addr_ack_o(addr_ack_o),
  .ld_ok_o(ld_ok_o), .priv_o(priv_o), .accept(accept), .st_cap(st_cap)
);

// File: tb/ldst_port_tb.sv
module ldst_port_tb;

  localparam int WORDS  = 16;
  localparam int ADDR_W = $clog2(WORDS) + 3;
  localparam int NBYTE  = WORDS * 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld_req_i = 0, st_req_i = 0, priv_i = 0, addr_vld_i = 0, st_vld_i = 0;
  logic [1:0]        size_i = 0;
  logic [ADDR_W-1:0] addr_i = 0;
  logic [63:0]       st_data_i = 0;
  logic              busy_o, addr_ack_o, ld_ok_o, priv_o;
  logic [63:0]       ld_data_o;

  logic [7:0] refm [NBYTE];
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  ldst_port #(.WORDS(WORDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_req_i(ld_req_i), .st_req_i(st_req_i),
    .size_i(size_i), .priv_i(priv_i), .addr_i(addr_i), .addr_vld_i(addr_vld_i),
    .st_data_i(st_data_i), .st_vld_i(st_vld_i), .busy_o(busy_o),
    .addr_ack_o(addr_ack_o), .ld_data_o(ld_data_o), .ld_ok_o(ld_ok_o), .priv_o(priv_o)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_load(input int a, input int sz);
    logic [63:0] v = '0;
    for (int i = 0; i < (1 << sz); i++) v[i*8 +: 8] = refm[a + i];
    return v;
  endfunction

  task automatic do_store(input int a, input int sz, input logic [63:0] d, input logic pv);
    @(negedge clk);
    st_req_i = 1; size_i = 2'(sz); addr_i = ADDR_W'(a); addr_vld_i = 1; priv_i = pv;
    do @(negedge clk); while (!addr_ack_o);
    st_data_i = d; st_vld_i = 1;
    @(negedge clk);
    st_vld_i = 0;
    chk(busy_o == 1'b1, "R4 commit busy", 64'(busy_o), 64'd1);
    @(negedge clk);
    chk(busy_o == 1'b0, "R4 busy released", 64'(busy_o), 64'd0);
    st_req_i = 0; addr_vld_i = 0;
    @(negedge clk);
    for (int i = 0; i < (1 << sz); i++) refm[a + i] = d[i*8 +: 8];
  endtask

  task automatic do_load(input int a, input int sz, input logic pv, output logic [63:0] q, output int lat);
    @(negedge clk);
    ld_req_i = 1; size_i = 2'(sz); addr_i = ADDR_W'(a); addr_vld_i = 1; priv_i = pv;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!ld_ok_o);
    q = ld_data_o;
    @(negedge clk);
    chk(ld_ok_o && busy_o, "R5 ok held", 64'({ld_ok_o, busy_o}), 64'd3);
    ld_req_i = 0; addr_vld_i = 0;
    @(negedge clk);
    chk(!busy_o && !ld_ok_o, "R8 idle after load", 64'({busy_o, ld_ok_o}), 64'd0);
  endtask

  task automatic load_chk(input int a, input int sz, input string req);
    logic [63:0] q;
    int lat;
    do_load(a, sz, 1'b0, q, lat);
    chk(q == ref_load(a, sz), req, q, ref_load(a, sz));
    chk(lat == 3, "R5 latency", 64'(lat), 64'd3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] q, pat;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !addr_ack_o && !ld_ok_o && ld_data_o == 0, "R1 reset idle",
        64'({busy_o, addr_ack_o, ld_ok_o}), 64'd0);

    // fill memory with full words (R2 8-byte size)
    for (int w = 0; w < WORDS; w++)
      do_store(w * 8, 3, 64'h0101_0101_0101_0101 * 64'(w + 1) ^ 64'h8040_2010_0804_0201, 1'b0);
    for (int w = 0; w < WORDS; w++) load_chk(w * 8, 3, "R2 full word");

    // sweep sizes and aligned offsets; check partial lanes (R3) and zero extension (R6)
    for (int w = 2; w < 6; w++)
      for (int sz = 0; sz < 4; sz++)
        for (int o = 0; o < 8; o += (1 << sz)) begin
          pat = 64'hA5C3_1E7F_9B24_6D58 + 64'(w * 97 + sz * 13 + o * 5);
          do_store(w * 8 + o, sz, pat, 1'b0);
          load_chk(w * 8 + o, sz, "R6 same-size readback");
          load_chk(w * 8, 3, "R3 neighbour lanes kept");
        end

    // little-endian pairing: two halves then one 4-byte load (R6)
    do_store(40, 1, 64'h0000_0000_0000_BEEF, 1'b0);
    do_store(42, 1, 64'h0000_0000_0000_CAFE, 1'b0);
    do_load(40, 2, 1'b0, q, lat);
    chk(q == 64'h0000_0000_CAFE_BEEF, "R6 little-endian pair", q, 64'h0000_0000_CAFE_BEEF);

    // privilege bit captured at acceptance (R9)
    do_load(48, 0, 1'b1, q, lat);
    chk(priv_o == 1'b1, "R9 priv captured", 64'(priv_o), 64'd1);
    priv_i = 0;
    repeat (2) @(negedge clk);
    chk(priv_o == 1'b1, "R9 priv held", 64'(priv_o), 64'd1);
    do_store(48, 0, 64'h11, 1'b0);
    chk(priv_o == 1'b0, "R9 priv recaptured", 64'(priv_o), 64'd0);

    // stray data pulse while idle (R7)
    @(negedge clk);
    st_data_i = 64'hFFFF_FFFF_FFFF_FFFF; st_vld_i = 1;
    @(negedge clk);
    st_vld_i = 0;
    load_chk(0, 3, "R7 idle pulse ignored");

    // stray data pulse during a load (R7)
    @(negedge clk);
    ld_req_i = 1; size_i = 3; addr_i = ADDR_W'(8); addr_vld_i = 1;
    @(negedge clk);
    st_data_i = 64'h0; st_vld_i = 1;
    @(negedge clk);
    st_vld_i = 0;
    do @(negedge clk); while (!ld_ok_o);
    ld_req_i = 0; addr_vld_i = 0;
    @(negedge clk);
    load_chk(8, 3, "R7 load pulse ignored");

    // store dropped before data (R8)
    @(negedge clk);
    st_req_i = 1; size_i = 3; addr_i = ADDR_W'(16); addr_vld_i = 1;
    @(negedge clk);
    chk(addr_ack_o == 1'b1, "R1 ack raised", 64'(addr_ack_o), 64'd1);
    st_req_i = 0; addr_vld_i = 0;
    @(negedge clk);
    chk(!busy_o && !addr_ack_o, "R8 abort to idle", 64'({busy_o, addr_ack_o}), 64'd0);
    st_data_i = 64'h0; st_vld_i = 1;
    @(negedge clk);
    st_vld_i = 0;
    load_chk(16, 3, "R8 aborted store wrote nothing");

    // load dropped in read phase (R8)
    @(negedge clk);
    ld_req_i = 1; size_i = 0; addr_i = ADDR_W'(3); addr_vld_i = 1;
    @(negedge clk);
    @(negedge clk);
    ld_req_i = 0; addr_vld_i = 0;
    @(negedge clk);
    chk(!busy_o && !ld_ok_o && !addr_ack_o, "R8 load abort idle",
        64'({busy_o, ld_ok_o, addr_ack_o}), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule